// File: doc/BRIEF.md
# Oversampled Type B Command Receiver

This block turns the reader-to-card command stream of a proximity card front end into bytes. Its input is a single hard-decided line level that an upstream sampler delivers four times per bit period, one sample per strobe. The receiver waits for a start-of-frame made of a long low phase followed by a high phase. It then deframes ten-bit characters made of a low start bit, eight data bits sent least significant first, and a high stop bit. Each data byte goes out on a one-cycle byte strobe.

A character whose ten bits are all low closes the frame. The receiver then reports how many bytes the frame held. Overlong low phases, overlong idle gaps between characters, malformed characters and frames that reach the byte limit abandon the frame, raise a one-cycle error pulse and send the receiver back to searching for a start-of-frame. The receiver does not check CRCs and does not interpret commands.

Top module: `obrx_cmd_rx`

## Requirements
- R1: After a synchronous active-low reset, byte_valid, frame_done and rx_error are low, and byte_data and frame_len are zero.
- R2: Phase 0 is the low sample that opened the start-of-frame or the character. The line is judged only on the sample at phase 2 of each four-sample bit period, so the other three samples of a data bit have no effect on the decoded byte.
- R3: A start-of-frame is accepted when at least 10 and at most 12 consecutive bit periods judge low and the next judged bit is high.
- R4: A low phase that judges fewer than 10 low bit periods before a high is treated as a glitch. The receiver returns to idle with no byte, no frame_done and no rx_error.
- R5: A 13th consecutive low judgement during a start-of-frame abandons it with one rx_error pulse.
- R6: Between characters the line may stay high for the stop bit's trailing sample plus up to 24 further samples. The 25th further high sample raises rx_error and abandons the frame.
- R7: A character with start bit 0 (first bit) and stop bit 1 (tenth bit) puts its eight middle bits on byte_data, first-received bit in bit 0, with a one-cycle byte_valid.
- R8: A character with all ten bits 0 ends the frame. If at least one byte was received, frame_done pulses for one cycle with frame_len equal to the byte count. With no bytes there is no frame_done and no rx_error.
- R9: Any other ten-bit pattern raises rx_error, gives no frame_done and returns the receiver to idle.
- R10: The byte that brings the count to MAX_BYTES is still delivered. It also raises rx_error and abandons the frame, so frame_done never follows.
- R11: byte_valid, frame_done and rx_error are single-cycle pulses registered on the clock edge that takes the deciding sample strobe. frame_done and rx_error never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe, one per line sample |
| line_in | input | 1 | Hard-decided line level for this sample |
| byte_valid | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | 8 | Received data byte |
| frame_done | output | 1 | One-cycle strobe at a valid end-of-frame |
| frame_len | output | LEN_W | Byte count of the completed frame |
| rx_error | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
Every result is decided on a sample strobe, and the matching output pulse is high during the clock cycle right after the edge that took that strobe. The bench raises the strobe on every other clock and records outputs on falling edges. It also registers the strobe in its own flop and counts any pulse whose preceding edge carried no strobe, which holds each result to exactly one clock of latency. The boundary tests count samples exactly: start-of-frame lengths of 9, 10, 12 and 13 bit periods, and inter-character gaps of 24 and 25 extra samples.

// File: rtl/obrx_pkg.sv
// Shared types for the oversampled command receiver.
// Assumes one ten-bit character format: start, eight data bits, stop.
package obrx_pkg;
    localparam int CHAR_BITS = 10;
    localparam int DATA_BITS = CHAR_BITS - 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a low that could open a start-of-frame
        ST_SOF  = 2'd1,   // measuring the low phase of a start-of-frame
        ST_GAP  = 2'd2,   // waiting for the start bit of the next character
        ST_DATA = 2'd3    // collecting the ten bits of a character
    } rx_state_t;
endpackage

// File: rtl/obrx_char_shift.sv
// Character shifter: collects judged bits of one character, newest at the top.
// Assumes the controller clears it at each start bit and shifts once per judged bit.
module obrx_char_shift
    import obrx_pkg::*;
#(
    parameter int NBITS = CHAR_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [NBITS-1:0] chr_next,
    output logic             last_bit
);
    localparam int NB_W = $clog2(NBITS + 1);

    logic [NBITS-1:0] chr;
    logic [NB_W-1:0]  nbits;

    // Value after the current bit is shifted in, available in the same cycle
    always_comb begin
        chr_next = {bit_in, chr[NBITS-1:1]};
        last_bit = (nbits == NB_W'(NBITS - 1));
    end

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            chr   <= '0;
            nbits <= '0;
        end else if (shift_en) begin
            chr   <= chr_next;
            nbits <= nbits + 1'b1;
        end
    end
endmodule

// File: rtl/obrx_char_decode.sv
// Character classifier: splits a complete character into data, end-of-frame or bad.
// Assumes bit 0 is the start bit and the top bit is the stop bit.
module obrx_char_decode
    import obrx_pkg::*;
(
    input  logic [CHAR_BITS-1:0] chr,
    output logic                 is_data,
    output logic                 is_eof,
    output logic [DATA_BITS-1:0] data
);
    // Pure decode of the framing bits
    always_comb begin
        is_data = chr[CHAR_BITS-1] & ~chr[0];
        is_eof  = (chr == '0);
        data    = chr[CHAR_BITS-2:1];
    end
endmodule

// File: rtl/obrx_byte_count.sv
// Frame byte counter with a look-ahead flag for the byte that reaches the limit.
// Assumes clear and inc are never asserted together.
module obrx_byte_count #(
    parameter int MAX_BYTES = 256,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    // Flags the current count as the one whose next byte reaches the limit
    always_comb at_limit = (count == CNT_W'(MAX_BYTES - 1));

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/obrx_cmd_rx.sv
// Oversampled command receiver top: start-of-frame qualification, character
// deframing, end-of-frame detection and frame abandonment.
// Assumes SMP_PER_BIT line samples per bit period, one per smp_en strobe, and
// that every output is a one-cycle pulse registered on the deciding strobe.
module obrx_cmd_rx
    import obrx_pkg::*;
#(
    parameter int SMP_PER_BIT  = 4,
    parameter int SOF_MIN_BITS = 10,
    parameter int SOF_MAX_BITS = 12,
    parameter int GAP_MAX_SMP  = 25,
    parameter int MAX_BYTES    = 256,
    parameter int LEN_W        = $clog2(MAX_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_en,
    input  logic                 line_in,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 frame_done,
    output logic [LEN_W-1:0]     frame_len,
    output logic                 rx_error
);
    localparam int EVAL_PH = SMP_PER_BIT / 2;
    localparam int POS_MAX = (GAP_MAX_SMP + 1 > SMP_PER_BIT) ? GAP_MAX_SMP + 1 : SMP_PER_BIT;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam int LOW_W   = $clog2(SOF_MAX_BITS + 1);

    rx_state_t            st, st_n;
    logic [POS_W-1:0]     pos, pos_n, pos_inc, pos_wrap;
    logic [LOW_W-1:0]     low_cnt, low_n;
    logic                 eval;

    logic                 shift_en, shift_clr;
    logic [CHAR_BITS-1:0] chr_next;
    logic                 last_bit;
    logic                 is_data, is_eof;
    logic [DATA_BITS-1:0] dec_data;

    logic                 cnt_clr, cnt_inc, at_limit;
    logic [LEN_W-1:0]     byte_cnt;

    logic                 bv_n, fd_n, er_n;
    logic [DATA_BITS-1:0] bd_n;
    logic [LEN_W-1:0]     len_n;

    obrx_char_shift #(.NBITS(CHAR_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (shift_clr),
        .shift_en (shift_en),
        .bit_in   (line_in),
        .chr_next (chr_next),
        .last_bit (last_bit)
    );

    obrx_char_decode u_dec (
        .chr     (chr_next),
        .is_data (is_data),
        .is_eof  (is_eof),
        .data    (dec_data)
    );

    obrx_byte_count #(.MAX_BYTES(MAX_BYTES), .CNT_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clr),
        .inc      (cnt_inc),
        .count    (byte_cnt),
        .at_limit (at_limit)
    );

    // Sample phase arithmetic shared by the states
    always_comb begin
        pos_inc  = pos + 1'b1;
        pos_wrap = (pos_inc >= POS_W'(SMP_PER_BIT)) ? '0 : pos_inc;
        eval     = (pos_inc == POS_W'(EVAL_PH));
    end

    // Receiver control: next state, counters and output pulses per strobe
    always_comb begin
        st_n      = st;
        pos_n     = pos;
        low_n     = low_cnt;
        shift_en  = 1'b0;
        shift_clr = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        bv_n      = 1'b0;
        fd_n      = 1'b0;
        er_n      = 1'b0;
        bd_n      = byte_data;
        len_n     = frame_len;
        if (smp_en) begin
            unique case (st)
                ST_IDLE: begin
                    if (!line_in) begin
                        st_n  = ST_SOF;
                        pos_n = '0;
                        low_n = '0;
                    end
                end
                ST_SOF: begin
                    pos_n = pos_wrap;
                    if (eval) begin
                        if (line_in) begin
                            if (low_cnt >= LOW_W'(SOF_MIN_BITS)) begin
                                st_n    = ST_GAP;
                                pos_n   = '0;
                                cnt_clr = 1'b1;
                            end else begin
                                st_n = ST_IDLE;
                            end
                        end else if (low_cnt == LOW_W'(SOF_MAX_BITS)) begin
                            st_n = ST_IDLE;
                            er_n = 1'b1;
                        end else begin
                            low_n = low_cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (!line_in) begin
                        st_n      = ST_DATA;
                        pos_n     = '0;
                        shift_clr = 1'b1;
                    end else if (pos_inc > POS_W'(GAP_MAX_SMP)) begin
                        st_n = ST_IDLE;
                        er_n = 1'b1;
                    end else begin
                        pos_n = pos_inc;
                    end
                end
                ST_DATA: begin
                    pos_n = pos_wrap;
                    if (eval) begin
                        shift_en = 1'b1;
                        if (last_bit) begin
                            if (is_data) begin
                                bv_n    = 1'b1;
                                bd_n    = dec_data;
                                cnt_inc = 1'b1;
                                if (at_limit) begin
                                    st_n = ST_IDLE;
                                    er_n = 1'b1;
                                end else begin
                                    st_n  = ST_GAP;
                                    pos_n = '0;
                                end
                            end else if (is_eof) begin
                                st_n = ST_IDLE;
                                if (byte_cnt != '0) begin
                                    fd_n  = 1'b1;
                                    len_n = byte_cnt;
                                end
                            end else begin
                                st_n = ST_IDLE;
                                er_n = 1'b1;
                            end
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State, phase and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            pos        <= '0;
            low_cnt    <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_done <= 1'b0;
            frame_len  <= '0;
            rx_error   <= 1'b0;
        end else begin
            st         <= st_n;
            pos        <= pos_n;
            low_cnt    <= low_n;
            byte_valid <= bv_n;
            byte_data  <= bd_n;
            frame_done <= fd_n;
            frame_len  <= len_n;
            rx_error   <= er_n;
        end
    end
endmodule

// File: rtl/obrx_cmd_rx_chk.sv
// Protocol checker for obrx_cmd_rx: output pulse shape, latency and length limits.
// Assumes the synchronous active-low reset of the receiver.
module obrx_cmd_rx_chk #(
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_en,
    input logic             byte_valid,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic             rx_error
);
    // R11: end-of-frame and abandonment are never reported together
    p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && rx_error));

    // R11: every pulse follows an edge that took a sample strobe
    p_pulse_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || frame_done || rx_error) |-> $past(smp_en));

    // R11: byte strobe lasts one cycle
    p_byte_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R8: a completed frame has a length between one and the limit
    p_done_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_len != '0) && (frame_len <= LEN_W'(MAX_BYTES)));

    // R8: the terminating character is not also a data byte
    p_done_no_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !byte_valid);

    // R8: the reported length only moves with frame_done
    p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(frame_len));
endmodule

bind obrx_cmd_rx obrx_cmd_rx_chk #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .byte_valid (byte_valid),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .rx_error   (rx_error)
);

// File: tb/sim_obrx_cmd_rx.sv
// Directed bench for obrx_cmd_rx: one task per scenario, strobe every other clock.
module sim_obrx_cmd_rx;
    localparam int MAXB  = 4;
    localparam int LEN_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_en = 1'b0;
    logic             line_in = 1'b1;
    logic             byte_valid;
    logic [7:0]       byte_data;
    logic             frame_done;
    logic [LEN_W-1:0] frame_len;
    logic             rx_error;

    always #4 clk = ~clk;

    obrx_cmd_rx #(.MAX_BYTES(MAXB)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en     (smp_en),
        .line_in    (line_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_done (frame_done),
        .frame_len  (frame_len),
        .rx_error   (rx_error)
    );

    int nchk = 0, nfail = 0;
    int nbytes = 0, ndone = 0, nerr = 0, last_len = 0;
    int nlate = 0, nclash = 0;
    logic [7:0] got [16];
    logic [7:0] tx [8];
    logic smp_q = 1'b0;

    // Registered copy of the strobe, taken on the same edge as the design
    always @(posedge clk) smp_q <= smp_en;

    // Output monitor, sampled at falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (nbytes < 16) got[nbytes] = byte_data;
                nbytes++;
            end
            if (frame_done) begin
                ndone++;
                last_len = int'(frame_len);
            end
            if (rx_error) nerr++;
            if ((byte_valid || frame_done || rx_error) && !smp_q) nlate++;
            if (frame_done && rx_error) nclash++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        nbytes = 0; ndone = 0; nerr = 0; last_len = 0;
    endtask

    task automatic send_smp(input logic v);
        @(negedge clk);
        line_in = v;
        smp_en  = 1'b1;
        @(negedge clk);
        smp_en  = 1'b0;
    endtask

    task automatic send_bit(input logic v, input bit noisy);
        for (int ph = 0; ph < 4; ph++) begin
            if (noisy && (ph == 1 || ph == 3)) send_smp(~v);
            else send_smp(v);
        end
    endtask

    task automatic send_char(input logic [7:0] b, input bit noisy);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i], noisy);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic send_sof(input int nlow);
        for (int i = 0; i < nlow; i++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic send_eof();
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_smp(1'b1);
    endtask

    task automatic chk_bytes(input string req, input int n);
        chk({req, " byte count"}, nbytes, n);
        for (int i = 0; i < n; i++) chk({req, " byte value"}, int'(got[i]), int'(tx[i]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        chk("R1 rx_error", int'(rx_error), 0);
        chk("R1 byte_data", int'(byte_data), 0);
        chk("R1 frame_len", int'(frame_len), 0);
    endtask

    task automatic t_basic();
        clr_mon();
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h01;
        idle(8); send_sof(10);
        for (int i = 0; i < 3; i++) send_char(tx[i], 1'b0);
        send_eof(); idle(8);
        chk_bytes("R7 R3", 3);
        chk("R8 frame_done count", ndone, 1);
        chk("R8 frame_len", last_len, 3);
        chk("R3 no error", nerr, 0);
    endtask

    task automatic t_noise_sof12();
        clr_mon();
        tx[0] = 8'h00; tx[1] = 8'hFF; tx[2] = 8'h96;
        send_sof(12);
        for (int i = 0; i < 3; i++) send_char(tx[i], 1'b1);
        send_eof(); idle(8);
        chk_bytes("R2 R3", 3);
        chk("R2 frame_done count", ndone, 1);
        chk("R2 frame_len", last_len, 3);
        chk("R2 no error", nerr, 0);
    endtask

    task automatic t_sof_short();
        clr_mon();
        send_sof(9); idle(20);
        chk("R4 bytes", nbytes, 0);
        chk("R4 frame_done", ndone, 0);
        chk("R4 no error", nerr, 0);
    endtask

    task automatic t_sof_long();
        clr_mon();
        for (int i = 0; i < 13; i++) send_bit(1'b0, 1'b0);
        idle(12);
        chk("R5 error", nerr, 1);
        chk("R5 bytes", nbytes, 0);
        clr_mon();
        tx[0] = 8'h42;
        send_sof(11); send_char(tx[0], 1'b0); send_eof(); idle(8);
        chk_bytes("R5 recovery", 1);
        chk("R5 recovery frame_len", last_len, 1);
        chk("R5 recovery no error", nerr, 0);
    endtask

    task automatic t_gap();
        clr_mon();
        tx[0] = 8'h11; tx[1] = 8'h22;
        send_sof(10); send_char(tx[0], 1'b0); idle(24);
        send_char(tx[1], 1'b0); send_eof(); idle(8);
        chk_bytes("R6 gap 24", 2);
        chk("R6 gap 24 frame_len", last_len, 2);
        chk("R6 gap 24 no error", nerr, 0);
        clr_mon();
        tx[0] = 8'h33;
        send_sof(10); send_char(tx[0], 1'b0); idle(25); idle(8);
        chk("R6 gap 25 error", nerr, 1);
        chk("R6 gap 25 no done", ndone, 0);
        chk_bytes("R6 gap 25", 1);
    endtask

    task automatic t_framing();
        clr_mon();
        tx[0] = 8'h5A;
        send_sof(10); send_char(tx[0], 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        idle(20);
        chk("R9 error", nerr, 1);
        chk("R9 no done", ndone, 0);
        chk_bytes("R9", 1);
    endtask

    task automatic t_eof_empty();
        clr_mon();
        send_sof(10); send_eof(); idle(8);
        chk("R8 empty no done", ndone, 0);
        chk("R8 empty no error", nerr, 0);
        chk("R8 empty bytes", nbytes, 0);
    endtask

    task automatic t_overflow();
        clr_mon();
        tx[0] = 8'h10; tx[1] = 8'h20; tx[2] = 8'h30; tx[3] = 8'h40; tx[4] = 8'h50;
        send_sof(10);
        for (int i = 0; i < 5; i++) send_char(tx[i], 1'b0);
        idle(20);
        chk_bytes("R10", MAXB);
        chk("R10 error", nerr, 1);
        chk("R10 no done", ndone, 0);
    endtask

    task automatic t_timing();
        chk("R11 pulse latency", nlate, 0);
        chk("R11 done/error clash", nclash, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_noise_sof12();
        t_sof_short();
        t_sof_long();
        t_gap();
        t_framing();
        t_eof_empty();
        t_overflow();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule